// File: doc/BRIEF.md
# Burst-of-Two Quad-Rate SRAM Controller

This block is the bus-master side of a quad-data-rate SRAM that has separate read and write data ports and a fixed burst of two words. The user side has two independent request channels. A read request carries one address. A write request carries one address, two data words and a byte-enable mask for each word. Every accepted request turns into a two-word burst at address A and then A+1 in the memory. The memory side has one shared address bus, an active-low read select, an active-low write select, active-low byte-write selects, an outbound write-data bus and an inbound read-data bus.

Both edges of the memory clock are modelled in one synthesizable clock, `clk2x`, which runs at twice the memory rate. The output `memK` is high for the clk2x cycle that stands for the K rising-edge slot and low for the cycle that stands for the K-bar rising-edge slot. A read and a write can both start in the same K cycle. The read address occupies the K-high slot and the write address occupies the K-low slot. Returned read data is captured at a fixed latency and handed to the user as one valid pulse per beat, in request order. Each beat carries the address it belongs to, which comes from a small queue of outstanding read tags.

Top module: `qdrBurst2Ctrl`

## Requirements
- R1: During and directly after reset, `memRdSelN`, `memWrSelN` and every bit of `memByteSelN` are 1, `memK` is 0 and `rdRspValid` is 0.
- R2: `memK` toggles on every clk2x cycle. `memRdSelN` and `memWrSelN` can be 0 only in a cycle where `memK` is 1.
- R3: A write accepted on a request edge gives the next cycle (`memK`=1) with `memWrSelN`=0, `memWrData`=word 0 and `memByteSelN`=~mask 0. The cycle after that (`memK`=0) carries `memAddr`=write address, `memWrData`=word 1 and `memByteSelN`=~mask 1. Word 0 lands at A and word 1 at A+1.
- R4: Bit i of `memByteSelN`, when 0, writes byte lane i, which is data bits 8i+7 down to 8i. A lane whose bit is 1 keeps its old memory contents.
- R5: A read accepted on a request edge gives the next cycle (`memK`=1) with `memRdSelN`=0 and `memAddr`=read address. Counting that cycle as n, the memory returns word A in cycle n+3 and word A+1 in cycle n+4. `rdRspValid` is high with those words in cycles n+4 and n+5.
- R6: Read responses come out in request order. `rdRspAddr` equals A for the first beat of a burst and A+1 for the second beat.
- R7: When a read and a write are requested together, both are accepted on the same edge and issued in the same K cycle. The read address goes out in the `memK`=1 slot and the write address in the following `memK`=0 slot.
- R8: With no request pending, both selects stay 1 and `memAddr` and `memWrData` stay unchanged.
- R9: `rdReqReady` and `wrReqReady` are high only in cycles where `memK` is 0. `rdReqReady` is also low while TAG_DEPTH reads are awaiting data. With the default depth of 2 and latency of 3, a held read request therefore issues at K-high cycles n, n+2 and n+6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the memory clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| rdReqValid | input | 1 | Read request present |
| rdReqReady | output | 1 | Read request accepted on this edge if valid |
| rdReqAddr | input | AW | Read burst base address |
| wrReqValid | input | 1 | Write request present |
| wrReqReady | output | 1 | Write request accepted on this edge if valid |
| wrReqAddr | input | AW | Write burst base address |
| wrReqData0 | input | DW | Word written to A |
| wrReqData1 | input | DW | Word written to A+1 |
| wrReqBe0 | input | DW/8 | Byte enables for word 0, active high |
| wrReqBe1 | input | DW/8 | Byte enables for word 1, active high |
| rdRspValid | output | 1 | One read beat is valid |
| rdRspData | output | DW | Read beat data |
| rdRspAddr | output | AW | Address of this read beat |
| memK | output | 1 | Memory clock phase: 1 = K-high slot, 0 = K-low slot |
| memAddr | output | AW | Shared memory address bus |
| memRdSelN | output | 1 | Read select, active low |
| memWrSelN | output | 1 | Write select, active low |
| memByteSelN | output | DW/8 | Byte-write selects, active low |
| memWrData | output | DW | Write data to the memory |
| memRdData | input | DW | Read data from the memory |

## Verification
A read and a write can both start in one K cycle, and this is where the shared address bus matters most. The bench provokes it by raising both request valids in the same clock, so both are accepted on one edge. It then checks four things: both selects went low in the same K-high cycle, the read address was on the bus in that slot, the write address followed in the K-low slot, and the read returned the memory contents from before the write. A later read of the written burst confirms that the write was not lost to the shared address slot.

// File: rtl/qdrPkg.sv
package qdrPkg;

  // strobes from the control to the datapath, valid for the current clk2x cycle
  typedef struct packed {
    logic issueRd;   // read accepted; K-high slot follows
    logic issueWr;   // write accepted; K-high slot follows with beat 0
    logic wrBeat1;   // K-high write slot in progress; K-low slot follows with beat 1
    logic capBeat0;  // first read beat is on memRdData now
    logic capBeat1;  // second read beat is on memRdData now
  } qdrStrobe_t;

endpackage

// File: rtl/qdrTagFifo.sv
module qdrTagFifo #(
  parameter int W     = 20,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  assign head  = store[rdPtr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= din;
        wrPtr        <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (pop) begin
        rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_TAG_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (!full || pop)) else $error("tag queue overflow"); // R9
  AST_TAG_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty) else $error("read beat with no outstanding tag"); // R6

endmodule

// File: rtl/qdrCtrl.sv
module qdrCtrl
  import qdrPkg::*;
#(
  parameter int RD_LAT2X = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReqValid,
  input  logic       wrReqValid,
  input  logic       tagFull,
  output logic       rdReqReady,
  output logic       wrReqReady,
  output logic       memK,
  output logic       memRdSelN,
  output logic       memWrSelN,
  output qdrStrobe_t strb
);
  localparam int PIPE_W = RD_LAT2X + 2;

  logic              kPhase;
  logic              wrPend;
  logic [PIPE_W-1:0] rdPipe;

  // requests are taken only on the edge that opens a K-high slot
  assign rdReqReady = !kPhase && !tagFull;
  assign wrReqReady = !kPhase;
  assign memK       = kPhase;

  always_comb begin
    strb          = '0;
    strb.issueRd  = rdReqValid && rdReqReady;
    strb.issueWr  = wrReqValid && wrReqReady;
    strb.wrBeat1  = kPhase && wrPend;
    strb.capBeat0 = rdPipe[RD_LAT2X];
    strb.capBeat1 = rdPipe[RD_LAT2X+1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kPhase    <= 1'b0;
      memRdSelN <= 1'b1;
      memWrSelN <= 1'b1;
      wrPend    <= 1'b0;
      rdPipe    <= '0;
    end else begin
      kPhase    <= !kPhase;
      memRdSelN <= !strb.issueRd;
      memWrSelN <= !strb.issueWr;
      wrPend    <= strb.issueWr;
      rdPipe    <= {rdPipe[PIPE_W-2:0], strb.issueRd};
    end
  end

  AST_K_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    memK |=> !memK) else $error("K phase stuck high"); // R2
  AST_SEL_ONLY_KHIGH: assert property (@(posedge clk) disable iff (!rstN)
    !memK |-> (memRdSelN && memWrSelN)) else $error("select low in K-low slot"); // R2
  AST_WR_ONE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    !memWrSelN |=> (memWrSelN && !memK)) else $error("write select held past its slot"); // R3
  AST_READY_KLOW: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqReady || wrReqReady) |=> memK) else $error("request taken off the K-high boundary"); // R9

endmodule

// File: rtl/qdrDatapath.sv
module qdrDatapath
  import qdrPkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int TAG_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  qdrStrobe_t      strb,
  input  logic [AW-1:0]   rdReqAddr,
  input  logic [AW-1:0]   wrReqAddr,
  input  logic [DW-1:0]   wrReqData0,
  input  logic [DW-1:0]   wrReqData1,
  input  logic [DW/8-1:0] wrReqBe0,
  input  logic [DW/8-1:0] wrReqBe1,
  input  logic [DW-1:0]   memRdData,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWrData,
  output logic [DW/8-1:0] memByteSelN,
  output logic            rdRspValid,
  output logic [DW-1:0]   rdRspData,
  output logic [AW-1:0]   rdRspAddr,
  output logic            tagFull
);
  localparam int BW = DW / 8;

  logic [AW-1:0] wrAddrQ;
  logic [DW-1:0] wrData1Q;
  logic [BW-1:0] wrBe1Q;
  logic [AW-1:0] tagHead;
  logic          tagEmpty;
  logic          rspSecond;

  // write beat 1 and its address wait one clk2x cycle for the K-low slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddrQ  <= '0;
      wrData1Q <= '0;
      wrBe1Q   <= '0;
    end else if (strb.issueWr) begin
      wrAddrQ  <= wrReqAddr;
      wrData1Q <= wrReqData1;
      wrBe1Q   <= wrReqBe1;
    end
  end

  // shared address bus: read in K-high slot, write in K-low slot, else hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memWrData <= '0;
    end else begin
      if (strb.issueRd)      memAddr <= rdReqAddr;
      else if (strb.wrBeat1) memAddr <= wrAddrQ;
      if (strb.issueWr)      memWrData <= wrReqData0;
      else if (strb.wrBeat1) memWrData <= wrData1Q;
    end
  end

  for (genvar g = 0; g < BW; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN)             memByteSelN[g] <= 1'b1;
      else if (strb.issueWr) memByteSelN[g] <= !wrReqBe0[g];
      else if (strb.wrBeat1) memByteSelN[g] <= !wrBe1Q[g];
      else                   memByteSelN[g] <= 1'b1;
    end
  end

  qdrTagFifo #(.W(AW), .DEPTH(TAG_DEPTH)) i_tagFifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (strb.issueRd),
    .din   (rdReqAddr),
    .pop   (strb.capBeat1),
    .head  (tagHead),
    .full  (tagFull),
    .empty (tagEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdRspValid <= 1'b0;
      rdRspData  <= '0;
      rdRspAddr  <= '0;
      rspSecond  <= 1'b0;
    end else begin
      rdRspValid <= strb.capBeat0 || strb.capBeat1;
      rspSecond  <= strb.capBeat1;
      if (strb.capBeat0 || strb.capBeat1) begin
        rdRspData <= memRdData;
        rdRspAddr <= strb.capBeat1 ? tagHead + 1'b1 : tagHead;
      end
    end
  end

  AST_RSP_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (rdRspValid && !rspSecond) |=> (rdRspValid && rspSecond)) else $error("lone read beat"); // R5
  AST_RSP_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdRspValid && !rspSecond) |=> (rdRspAddr == $past(rdRspAddr) + 1'b1)) else $error("beat address step"); // R6
  AST_IDLE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.issueRd && !strb.wrBeat1) |=> $stable(memAddr)) else $error("address moved while idle"); // R8

endmodule

// File: rtl/qdrBurst2Ctrl.sv
module qdrBurst2Ctrl
  import qdrPkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int TAG_DEPTH = 2,
  parameter int RD_LAT2X  = 3
) (
  input  logic            clk2x,
  input  logic            rstN,
  input  logic            rdReqValid,
  output logic            rdReqReady,
  input  logic [AW-1:0]   rdReqAddr,
  input  logic            wrReqValid,
  output logic            wrReqReady,
  input  logic [AW-1:0]   wrReqAddr,
  input  logic [DW-1:0]   wrReqData0,
  input  logic [DW-1:0]   wrReqData1,
  input  logic [DW/8-1:0] wrReqBe0,
  input  logic [DW/8-1:0] wrReqBe1,
  output logic            rdRspValid,
  output logic [DW-1:0]   rdRspData,
  output logic [AW-1:0]   rdRspAddr,
  output logic            memK,
  output logic [AW-1:0]   memAddr,
  output logic            memRdSelN,
  output logic            memWrSelN,
  output logic [DW/8-1:0] memByteSelN,
  output logic [DW-1:0]   memWrData,
  input  logic [DW-1:0]   memRdData
);
  qdrStrobe_t strb;
  logic       tagFull;

  qdrCtrl #(.RD_LAT2X(RD_LAT2X)) i_ctrl (
    .clk        (clk2x),
    .rstN       (rstN),
    .rdReqValid (rdReqValid),
    .wrReqValid (wrReqValid),
    .tagFull    (tagFull),
    .rdReqReady (rdReqReady),
    .wrReqReady (wrReqReady),
    .memK       (memK),
    .memRdSelN  (memRdSelN),
    .memWrSelN  (memWrSelN),
    .strb       (strb)
  );

  qdrDatapath #(.AW(AW), .DW(DW), .TAG_DEPTH(TAG_DEPTH)) i_datapath (
    .clk         (clk2x),
    .rstN        (rstN),
    .strb        (strb),
    .rdReqAddr   (rdReqAddr),
    .wrReqAddr   (wrReqAddr),
    .wrReqData0  (wrReqData0),
    .wrReqData1  (wrReqData1),
    .wrReqBe0    (wrReqBe0),
    .wrReqBe1    (wrReqBe1),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .memByteSelN (memByteSelN),
    .rdRspValid  (rdRspValid),
    .rdRspData   (rdRspData),
    .rdRspAddr   (rdRspAddr),
    .tagFull     (tagFull)
  );

  AST_RESET_DESELECT: assert property (@(posedge clk2x)
    !rstN |=> (memRdSelN && memWrSelN && !rdRspValid && !memK)) else $error("not deselected after reset"); // R1

endmodule

// File: tb/test_qdrBurst2Ctrl.sv
module test_qdrBurst2Ctrl;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BW = DW / 8;

  logic          clk2x = 1'b0;
  logic          rstN  = 1'b0;
  logic          rdReqValid = 1'b0, wrReqValid = 1'b0;
  logic          rdReqReady, wrReqReady;
  logic [AW-1:0] rdReqAddr = '0, wrReqAddr = '0;
  logic [DW-1:0] wrReqData0 = '0, wrReqData1 = '0;
  logic [BW-1:0] wrReqBe0 = '0, wrReqBe1 = '0;
  logic          rdRspValid;
  logic [DW-1:0] rdRspData;
  logic [AW-1:0] rdRspAddr;
  logic          memK, memRdSelN, memWrSelN;
  logic [AW-1:0] memAddr;
  logic [BW-1:0] memByteSelN;
  logic [DW-1:0] memWrData;
  logic [DW-1:0] memRdData = '0;

  always #2 clk2x = !clk2x;

  qdrBurst2Ctrl i_qdrBurst2Ctrl (.*);

  int nChecks = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] expMem [256];
  logic [DW-1:0] sched [8];
  bit            schedV [8];

  int            rspCnt = 0;
  logic [DW-1:0] rspData [64];
  logic [AW-1:0] rspAddr [64];
  int            rspCyc [64];
  int            rdCnt = 0;
  int            rdCyc [64];
  logic [AW-1:0] rdAddrLog [64];
  int            wrCnt = 0;
  int            wrCyc [64];
  logic [AW-1:0] wrAddrLog [64];
  logic [DW-1:0] wrD0Log [64], wrD1Log [64];
  bit            wrPendM = 0;
  logic [DW-1:0] pendD0;
  logic [BW-1:0] pendBe0;
  int            r2Bad = 0;
  bit            prevK, prevOk = 0;

  always @(posedge clk2x) cyc++;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [BW-1:0] be);
    for (int i = 0; i < BW; i++) if (be[i]) o[8*i +: 8] = n[8*i +: 8];
    return o;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory model and monitors, acting mid-cycle
  always @(negedge clk2x) begin
    memRdData <= schedV[cyc & 7] ? sched[cyc & 7] : '0;
    schedV[cyc & 7] = 0;
    if (rstN) begin
      if (prevOk && memK == prevK) r2Bad++;
      if (!memK && (!memRdSelN || !memWrSelN)) r2Bad++;
      prevK  = memK;
      prevOk = 1;
      if (memK && !memRdSelN) begin
        sched[(cyc + 3) & 7] = mem[memAddr[7:0]];
        schedV[(cyc + 3) & 7] = 1;
        sched[(cyc + 4) & 7] = mem[8'(memAddr[7:0] + 8'd1)];
        schedV[(cyc + 4) & 7] = 1;
        rdCyc[rdCnt] = cyc;
        rdAddrLog[rdCnt] = memAddr;
        rdCnt++;
      end
      if (memK && !memWrSelN) begin
        wrPendM = 1;
        pendD0  = memWrData;
        pendBe0 = ~memByteSelN;
        wrCyc[wrCnt] = cyc;
      end else if (!memK && wrPendM) begin
        mem[memAddr[7:0]] = merge(mem[memAddr[7:0]], pendD0, pendBe0);
        mem[8'(memAddr[7:0] + 8'd1)] = merge(mem[8'(memAddr[7:0] + 8'd1)], memWrData, ~memByteSelN);
        wrAddrLog[wrCnt] = memAddr;
        wrD0Log[wrCnt] = pendD0;
        wrD1Log[wrCnt] = memWrData;
        wrCnt++;
        wrPendM = 0;
      end
      if (rdRspValid) begin
        rspData[rspCnt] = rdRspData;
        rspAddr[rspCnt] = rdRspAddr;
        rspCyc[rspCnt]  = cyc;
        rspCnt++;
      end
    end
  end

  task automatic waitRsp(int target);
    for (int i = 0; i < 40 && rspCnt < target; i++) @(negedge clk2x);
  endtask

  task automatic doWrite(logic [AW-1:0] a, logic [DW-1:0] d0, logic [DW-1:0] d1,
                         logic [BW-1:0] b0, logic [BW-1:0] b1);
    int base = wrCnt;
    @(negedge clk2x);
    wrReqValid = 1; wrReqAddr = a; wrReqData0 = d0; wrReqData1 = d1;
    wrReqBe0 = b0; wrReqBe1 = b1;
    while (!wrReqReady) @(negedge clk2x);
    @(negedge clk2x);
    wrReqValid = 0;
    repeat (3) @(negedge clk2x);
    expMem[a[7:0]] = merge(expMem[a[7:0]], d0, b0);
    expMem[8'(a[7:0] + 8'd1)] = merge(expMem[8'(a[7:0] + 8'd1)], d1, b1);
    chk(wrCnt == base + 1 && wrAddrLog[base] == a, "R3 write address in K-low slot", wrAddrLog[base], a);
    chk(wrD0Log[base] == d0 && wrD1Log[base] == d1, "R3 write beats", {wrD0Log[base], wrD1Log[base]}, {d0, d1});
  endtask

  task automatic doRead(logic [AW-1:0] a, string req);
    int rb = rdCnt, sb = rspCnt;
    @(negedge clk2x);
    rdReqValid = 1; rdReqAddr = a;
    while (!rdReqReady) @(negedge clk2x);
    @(negedge clk2x);
    rdReqValid = 0;
    waitRsp(sb + 2);
    chk(rspCnt == sb + 2, {req, " two beats returned"}, rspCnt - sb, 2);
    chk(rspData[sb] == expMem[a[7:0]], {req, " beat0 data"}, rspData[sb], expMem[a[7:0]]);
    chk(rspData[sb+1] == expMem[8'(a[7:0] + 8'd1)], {req, " beat1 data"}, rspData[sb+1], expMem[8'(a[7:0] + 8'd1)]);
    chk(rspAddr[sb] == a && rspAddr[sb+1] == a + 1, "R6 beat addresses", {rspAddr[sb], rspAddr[sb+1]}, {a, a + 20'd1});
    chk(rdAddrLog[rb] == a, "R5 read address in K-high slot", rdAddrLog[rb], a);
    chk(rspCyc[sb] - rdCyc[rb] == 4 && rspCyc[sb+1] - rdCyc[rb] == 5, "R5 read latency",
        {32'(rspCyc[sb] - rdCyc[rb]), 32'(rspCyc[sb+1] - rdCyc[rb])}, {32'd4, 32'd5});
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk2x);
    chk(memRdSelN && memWrSelN && !memK && !rdRspValid && memByteSelN == '1,
        "R1 reset deselect", {memRdSelN, memWrSelN, memK, rdRspValid, memByteSelN}, 6'b110011);
    rstN = 1;
    @(negedge clk2x);
    chk(memRdSelN && memWrSelN && !rdRspValid, "R1 first cycle after reset",
        {memRdSelN, memWrSelN, rdRspValid}, 3'b110);
  endtask

  task automatic testBasic();
    doWrite(20'h10, 16'hAAAA, 16'h5555, 2'b11, 2'b11);
    doRead(20'h10, "R3");
  endtask

  task automatic testByteMask();
    doWrite(20'h10, 16'h1234, 16'h5678, 2'b01, 2'b10);
    chk(mem[8'h10] == 16'hAA34 && mem[8'h11] == 16'h5655, "R4 lane merge in memory",
        {mem[8'h10], mem[8'h11]}, 32'hAA34_5655);
    doRead(20'h10, "R4");
  endtask

  task automatic testConcurrent();
    int rb, wb, sb;
    logic [DW-1:0] old0, old1;
    doWrite(20'h20, 16'hC0DE, 16'hBEEF, 2'b11, 2'b11);
    old0 = expMem[8'h20]; old1 = expMem[8'h21];
    rb = rdCnt; wb = wrCnt; sb = rspCnt;
    @(negedge clk2x);
    rdReqValid = 1; rdReqAddr = 20'h20;
    wrReqValid = 1; wrReqAddr = 20'h30; wrReqData0 = 16'h0F0F; wrReqData1 = 16'hF0F0;
    wrReqBe0 = 2'b11; wrReqBe1 = 2'b11;
    while (!wrReqReady) @(negedge clk2x);
    @(negedge clk2x);
    rdReqValid = 0; wrReqValid = 0;
    waitRsp(sb + 2);
    chk(rdCnt == rb + 1 && wrCnt == wb + 1 && rdCyc[rb] == wrCyc[wb], "R7 same K cycle issue",
        rdCyc[rb], wrCyc[wb]);
    chk(rdAddrLog[rb] == 20'h20 && wrAddrLog[wb] == 20'h30, "R7 slot order read then write",
        {rdAddrLog[rb], wrAddrLog[wb]}, {20'h20, 20'h30});
    chk(rspData[sb] == old0 && rspData[sb+1] == old1, "R7 read sees prior contents",
        {rspData[sb], rspData[sb+1]}, {old0, old1});
    expMem[8'h30] = 16'h0F0F; expMem[8'h31] = 16'hF0F0;
    doRead(20'h30, "R7");
  endtask

  task automatic testBackToBack();
    logic [AW-1:0] al [3] = '{20'h10, 20'h20, 20'h30};
    int rb = rdCnt, sb = rspCnt;
    repeat (8) @(negedge clk2x);
    for (int k = 0; k < 3; k++) begin
      rdReqValid = 1; rdReqAddr = al[k];
      while (!rdReqReady) @(negedge clk2x);
      @(negedge clk2x);
    end
    rdReqValid = 0;
    waitRsp(sb + 6);
    chk(rdCyc[rb+1] - rdCyc[rb] == 2, "R9 second read next K cycle", rdCyc[rb+1] - rdCyc[rb], 2);
    chk(rdCyc[rb+2] - rdCyc[rb] == 6, "R9 third read stalled by full tags", rdCyc[rb+2] - rdCyc[rb], 6);
    for (int k = 0; k < 3; k++) begin
      chk(rspAddr[sb+2*k] == al[k] && rspAddr[sb+2*k+1] == al[k] + 1, "R6 response order",
          rspAddr[sb+2*k], al[k]);
      chk(rspData[sb+2*k] == expMem[al[k][7:0]], "R6 ordered data", rspData[sb+2*k], expMem[al[k][7:0]]);
    end
  endtask

  task automatic testIdle();
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    bit bad = 0;
    repeat (4) @(negedge clk2x);
    a0 = memAddr; d0 = memWrData;
    repeat (10) begin
      @(negedge clk2x);
      if (memAddr != a0 || memWrData != d0 || !memRdSelN || !memWrSelN) bad = 1;
    end
    chk(!bad, "R8 idle bus held", memAddr, a0);
    chk(!rdReqReady || !memK, "R9 ready only in K-low", rdReqReady, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0101); expMem[i] = 16'(i * 16'h0101);
    end
    for (int i = 0; i < 8; i++) schedV[i] = 0;
    testReset();
    testBasic();
    testByteMask();
    testConcurrent();
    testBackToBack();
    testIdle();
    chk(r2Bad == 0, "R2 K toggling and select slot", r2Bad, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk2x);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule